// File: doc/BRIEF.md
# Complementary Dead-Time Inserter

This block turns one phase's raw high-side request into a pair of complementary, active-low gate signals for a half bridge. Each time the request changes, both switches are held off for a programmable number of clock cycles before the newly requested switch is turned on. The turn-on delay for the high side and the turn-on delay for the low side are programmed separately, so the gap may be asymmetric.

The gap is timed by a counter inside this block rather than by the period timer. A gap therefore runs to its full length even when it crosses into the next switching period. The two delay inputs are double-buffered. A new value only takes effect at the edge that samples the period sync pulse. Narrow pulses get a gap on both edges. Pulses shorter than the gap are absorbed: the gap restarts toward the reversed request. A phase held constantly on or off sees no further gaps. A force-off input shuts both switches off at once, whatever the block is doing.

Top module: `dead_time_inserter`

## Requirements
- R1: While `rstN` is low, both gate outputs are 1 (inactive), and both working dead times hold the parameter value `RST_DEAD`. After reset is released, the first switch turned on is preceded by a full gap of its own dead time.
- R2: Suppose `cmdHigh` is sampled 1 at clock edge E while the low side is on. Both outputs are then 1 from E, and `gateHighN` becomes 0 at edge E+Dr, where Dr is the working high-side dead time (Dr > 0).
- R3: Suppose `cmdHigh` is sampled 0 at edge E while the high side is on. Both outputs are then 1 from E, and `gateLowN` becomes 0 at edge E+Df, where Df is the working low-side dead time (Df > 0).
- R4: A working dead time of zero switches directly at edge E, with no cycle in which both outputs are off.
- R5: `riseDead` and `fallDead` become the working values only at an edge that samples `periodSync` as 1. A transition sampled at that same edge uses the previous values. A gap already counting keeps the length it was loaded with, even across the sync.
- R6: If `cmdHigh` reverses while a gap is counting, the gap restarts at that edge toward the new side, using that side's dead time. A pulse shorter than the gap never turns its switch on.
- R7: While `cmdHigh` stays constant and force-off is low, a switch that is on stays on, and no gap is inserted.
- R8: When `forceOff` is sampled 1, both outputs are 1 from that edge for as long as it stays asserted. After release, the requested side turns on only after a full gap of its own dead time.
- R9: `gateHighN` and `gateLowN` are never both 0.
- R10: The encoding is active-low. `gateHighN`=0 means the high-side switch is on, and `gateLowN`=0 means the low-side switch is on. `cmdHigh`=1 requests the high side and `cmdHigh`=0 requests the low side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every gap is counted in its cycles |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdHigh | input | 1 | Raw request: 1 selects high side, 0 selects low side |
| riseDead | input | DT_W | Pending gap length before a high-side turn-on, in cycles |
| fallDead | input | DT_W | Pending gap length before a low-side turn-on, in cycles |
| periodSync | input | 1 | Period-boundary strobe that loads the pending gap lengths |
| forceOff | input | 1 | Forces both switches off from the next edge |
| gateHighN | output | 1 | High-side gate, active low |
| gateLowN | output | 1 | Low-side gate, active low |

## Verification
Two functions can land on the same clock edge. The first is the period-sync reload of the gap lengths. The second is the start or progress of a gap. The bench drives `periodSync` on the edge where `cmdHigh` flips, and also a few cycles into a running gap, each time with reload values far from the old ones. The behavioural reference model is judged cycle by cycle: the gap that starts at the sync edge must use the old length, and a gap already running must finish with its loaded length. A second collision is tested as well: force-off is asserted and released inside running gaps, and the resulting restart is compared the same way.

// File: rtl/dti_pkg.sv
package dti_pkg;

  // Conduction state of the half bridge
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,   // both off, no gap counting (reset / forced)
    ST_HIGH = 2'd1,   // high-side switch conducting
    ST_LOW  = 2'd2,   // low-side switch conducting
    ST_GAP  = 2'd3    // both off, counting toward a target side
  } dtiState_e;

  // Strobes from control to the gap datapath
  typedef struct packed {
    logic loadRise;   // start a gap before high-side turn-on
    logic loadFall;   // start a gap before low-side turn-on
    logic countDown;  // advance the running gap by one cycle
  } dtiStrobe_t;

endpackage

// File: rtl/dti_datapath.sv
module dti_datapath
  import dti_pkg::*;
#(
  parameter int DT_W     = 16,
  parameter int RST_DEAD = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DT_W-1:0] riseDead,
  input  logic [DT_W-1:0] fallDead,
  input  logic            periodSync,
  input  dtiStrobe_t      strb,
  output logic            riseZero,
  output logic            fallZero,
  output logic            gapDone
);

  localparam logic [DT_W-1:0] RST_VAL = DT_W'(RST_DEAD);
  localparam logic [DT_W-1:0] ONE     = DT_W'(1);

  logic [DT_W-1:0] activeRise;
  logic [DT_W-1:0] activeFall;
  logic [DT_W-1:0] gapCnt;

  // Working copies: refreshed only on the period strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeRise <= RST_VAL;
      activeFall <= RST_VAL;
    end else if (periodSync) begin
      activeRise <= riseDead;
      activeFall <= fallDead;
    end
  end

  // Gap counter: loaded with length-1, done when it reaches zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strb.loadRise) begin
      gapCnt <= activeRise - ONE;
    end else if (strb.loadFall) begin
      gapCnt <= activeFall - ONE;
    end else if (strb.countDown) begin
      gapCnt <= gapCnt - ONE;
    end
  end

  assign riseZero = (activeRise == '0);
  assign fallZero = (activeFall == '0);
  assign gapDone  = (gapCnt == '0);

endmodule

// File: rtl/dti_control.sv
module dti_control
  import dti_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdHigh,
  input  logic       forceOff,
  input  logic       riseZero,
  input  logic       fallZero,
  input  logic       gapDone,
  output dtiStrobe_t strb,
  output logic       gateHighN,
  output logic       gateLowN
);

  dtiState_e state, stateNext;
  logic      target, targetNext;
  logic      startMove;
  logic      zeroGap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OFF;
      target <= 1'b0;
    end else begin
      state  <= stateNext;
      target <= targetNext;
    end
  end

  always_comb begin
    stateNext  = state;
    targetNext = target;
    strb       = '0;
    startMove  = 1'b0;
    zeroGap    = cmdHigh ? riseZero : fallZero;

    unique case (state)
      ST_OFF:  startMove = 1'b1;
      ST_HIGH: startMove = !cmdHigh;
      ST_LOW:  startMove = cmdHigh;
      ST_GAP: begin
        if (cmdHigh != target) begin
          startMove = 1'b1;
        end else if (gapDone) begin
          stateNext = target ? ST_HIGH : ST_LOW;
        end else begin
          strb.countDown = 1'b1;
        end
      end
      default: stateNext = ST_OFF;
    endcase

    if (startMove) begin
      targetNext = cmdHigh;
      if (zeroGap) begin
        stateNext = cmdHigh ? ST_HIGH : ST_LOW;
      end else begin
        stateNext     = ST_GAP;
        strb.loadRise = cmdHigh;
        strb.loadFall = !cmdHigh;
      end
    end

    // Shutdown overrides everything
    if (forceOff) begin
      stateNext = ST_OFF;
      strb      = '0;
    end
  end

  assign gateHighN = (state != ST_HIGH);
  assign gateLowN  = (state != ST_LOW);

endmodule

// File: rtl/dead_time_inserter.sv
module dead_time_inserter
  import dti_pkg::*;
#(
  parameter int DT_W     = 16,
  parameter int RST_DEAD = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdHigh,
  input  logic [DT_W-1:0] riseDead,
  input  logic [DT_W-1:0] fallDead,
  input  logic            periodSync,
  input  logic            forceOff,
  output logic            gateHighN,
  output logic            gateLowN
);

  dtiStrobe_t strb;
  logic       riseZero;
  logic       fallZero;
  logic       gapDone;

  dti_datapath #(
    .DT_W    (DT_W),
    .RST_DEAD(RST_DEAD)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .riseDead  (riseDead),
    .fallDead  (fallDead),
    .periodSync(periodSync),
    .strb      (strb),
    .riseZero  (riseZero),
    .fallZero  (fallZero),
    .gapDone   (gapDone)
  );

  dti_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .cmdHigh  (cmdHigh),
    .forceOff (forceOff),
    .riseZero (riseZero),
    .fallZero (fallZero),
    .gapDone  (gapDone),
    .strb     (strb),
    .gateHighN(gateHighN),
    .gateLowN (gateLowN)
  );

endmodule

// File: rtl/dti_checker.sv
module dti_checker (
  input logic clk,
  input logic rstN,
  input logic cmdHigh,
  input logic forceOff,
  input logic gateHighN,
  input logic gateLowN
);

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !(!gateHighN && !gateLowN)); // R9

  AST_FORCE_SHUTS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    forceOff |=> (gateHighN && gateLowN)); // R8

  AST_HIGH_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !gateHighN |-> $past(cmdHigh)); // R10

  AST_LOW_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !gateLowN |-> !$past(cmdHigh)); // R10

  AST_HIGH_CLAMP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!gateHighN && cmdHigh && !forceOff) |=> !gateHighN); // R7

  AST_LOW_CLAMP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!gateLowN && !cmdHigh && !forceOff) |=> !gateLowN); // R7

endmodule

bind dead_time_inserter dti_checker i_dti_checker (.*);

// File: tb/test_dead_time_inserter.sv
module test_dead_time_inserter;

  localparam int CLK_PERIOD = 10;
  localparam int DT_W       = 16;
  localparam int RST_DEAD   = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdHigh = 1'b0;
  logic [DT_W-1:0] riseDead = '0;
  logic [DT_W-1:0] fallDead = '0;
  logic            periodSync = 1'b0;
  logic            forceOff = 1'b0;
  logic            gateHighN;
  logic            gateLowN;

  int    checks = 0;
  int    fails  = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dead_time_inserter #(.DT_W(DT_W), .RST_DEAD(RST_DEAD)) i_dead_time_inserter (
    .clk(clk), .rstN(rstN), .cmdHigh(cmdHigh), .riseDead(riseDead),
    .fallDead(fallDead), .periodSync(periodSync), .forceOff(forceOff),
    .gateHighN(gateHighN), .gateLowN(gateLowN)
  );

  // Behavioural reference: mode 0 idle, 1 high on, 2 low on, 3 waiting
  int mMode = 0;
  int mTarget = 0;
  int mLeft = 0;
  int mRise = RST_DEAD;
  int mFall = RST_DEAD;

  task automatic modelStart(int t);
    int d;
    d = (t != 0) ? mRise : mFall;
    mTarget = t;
    mLeft = d;
    if (d == 0) mMode = (t != 0) ? 1 : 2;
    else        mMode = 3;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mLeft = 0; mRise = RST_DEAD; mFall = RST_DEAD;
    end else begin
      if (forceOff) mMode = 0;
      else begin
        case (mMode)
          0: modelStart(int'(cmdHigh));
          1: if (!cmdHigh) modelStart(0);
          2: if (cmdHigh) modelStart(1);
          default: begin
            if (int'(cmdHigh) != mTarget) modelStart(int'(cmdHigh));
            else begin
              mLeft = mLeft - 1;
              if (mLeft <= 0) mMode = (mTarget != 0) ? 1 : 2;
            end
          end
        endcase
      end
      if (periodSync) begin
        mRise = int'(riseDead);
        mFall = int'(fallDead);
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    logic expH, expL;
    if (!finished) begin
      expH = (mMode == 1) ? 1'b0 : 1'b1;
      expL = (mMode == 2) ? 1'b0 : 1'b1;
      checks++;
      if (gateHighN !== expH || gateLowN !== expL) begin
        fails++;
        $display("FAIL %s: gates H/L = %b/%b, expected %b/%b at %0t",
                 tag, gateHighN, gateLowN, expH, expL, $time);
      end
      checks++;
      if (gateHighN === 1'b0 && gateLowN === 1'b0) begin
        fails++;
        $display("FAIL R9: gates H/L = 0/0, expected never both 0 at %0t", $time);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadDead(int r, int f);
    riseDead = DT_W'(r);
    fallDead = DT_W'(f);
    periodSync = 1'b1;
    tick(1);
    periodSync = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run incomplete, expected end before timeout");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset holds both off, then first turn-on waits RST_DEAD
    tag = "R1";
    cmdHigh = 1'b1;
    tick(4);
    checks++;
    if (gateHighN !== 1'b1 || gateLowN !== 1'b1) begin
      fails++;
      $display("FAIL R1: gates in reset %b/%b, expected 1/1", gateHighN, gateLowN);
    end
    rstN = 1'b1;
    tick(12);

    // R5: new asymmetric values loaded on sync
    tag = "R5 R2 R3 R10";
    loadDead(5, 3);
    cmdHigh = 1'b0; tick(20);
    cmdHigh = 1'b1; tick(20);
    cmdHigh = 1'b0; tick(20);

    // R7: long clamps on each side
    tag = "R7";
    cmdHigh = 1'b1; tick(60);
    cmdHigh = 1'b0; tick(60);

    // R6: narrow and absorbed pulses
    tag = "R6";
    cmdHigh = 1'b1; tick(2);
    cmdHigh = 1'b0; tick(10);
    cmdHigh = 1'b1; tick(7);
    cmdHigh = 1'b0; tick(2);
    cmdHigh = 1'b1; tick(1);
    cmdHigh = 1'b0; tick(12);

    // R5: sync on the same edge as a transition uses old values
    tag = "R5 same-edge";
    riseDead = 16'd2; fallDead = 16'd6;
    cmdHigh = 1'b1; periodSync = 1'b1;
    tick(1);
    periodSync = 1'b0;
    tick(15);
    // R5: sync inside a running gap keeps its loaded length
    tag = "R5 mid-gap";
    cmdHigh = 1'b0; tick(2);
    loadDead(9, 1);
    tick(15);
    cmdHigh = 1'b1; tick(4);
    loadDead(1, 9);
    tick(15);

    // R4: zero dead time switches directly
    tag = "R4";
    loadDead(0, 0);
    for (int i = 0; i < 6; i++) begin
      cmdHigh = ~cmdHigh; tick(3);
    end
    loadDead(0, 4);
    cmdHigh = 1'b0; tick(8);
    cmdHigh = 1'b1; tick(8);

    // R8: force-off during a gap, while on, and release
    tag = "R8";
    loadDead(5, 5);
    cmdHigh = 1'b0; tick(2);
    forceOff = 1'b1; tick(3);
    forceOff = 1'b0; tick(10);
    forceOff = 1'b1; tick(1);
    forceOff = 1'b0; cmdHigh = 1'b1; tick(12);

    // R2 R3 R6 R7: period-driven PWM with edge-of-range duties
    tag = "R2 R3 R6 R7 pwm";
    for (int p = 0; p < 40; p++) begin
      int ton, toff;
      ton  = (p * 7) % 21;
      toff = 20 - ((p * 3) % 21);
      for (int c = 0; c < 20; c++) begin
        cmdHigh = (c >= ton && c < toff);
        periodSync = (c == 0);
        if (c == 0) begin
          riseDead = DT_W'(1 + (p % 6));
          fallDead = DT_W'(p % 4);
        end
        tick(1);
      end
    end
    periodSync = 1'b0;

    // Random mix including rare force-off
    tag = "R6 R8 R9 random";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) cmdHigh = ~cmdHigh;
      forceOff = (lfsr[9:4] == 6'd5);
      periodSync = (lfsr[15:11] == 5'd3);
      riseDead = DT_W'(lfsr[6:5]);
      fallDead = DT_W'(lfsr[8:7] + 2'd1);
      tick(1);
    end
    forceOff = 1'b0; periodSync = 1'b0;
    tick(10);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule